// File: doc/BRIEF.md
# DDR2 Mode Register Load Sequencer

This controller-side block writes the four configuration registers of a DDR2 memory: the main mode register and extended registers 1, 2 and 3. It builds each register image from configuration inputs. The main register image is assembled from individual fields: burst length, burst type, CAS latency, DLL reset, write recovery and power-down exit mode. The three extended images are taken as full words. Each load is issued as a single command cycle on the command, bank-address and address pins, and the pins carry a no-operation command at all other times.

A load sequence runs once after reset. It runs again whenever a reprogram request arrives while the block is ready. Each load is held back until the memory reports all banks idle and the clock-enable input has been high for the current cycle and the cycle before. Consecutive loads are separated by a parameterised mode-register cycle time. A ready output tells the read/write scheduler that traffic may start. Ready stays low throughout every sequence and rises only after the last load's cycle time has elapsed.

Top module: `ddr2_mrs_seq`

## Requirements
- R1: A load cycle drives `cs_n`, `ras_n`, `cas_n` and `we_n` all low. Every other cycle after reset drives a no-operation: `cs_n` low and the other three high.
- R2: The bank address selects the register: 0 for the main register, 1 for extended register 1, 2 for extended register 2 and 3 for extended register 3. Load k of a sequence (k = 0..3) targets the code in `order[2k+1:2k]`. The order 2, 3, 1, 0 is written as 8'h1E.
- R3: A load appears on the pins only in the cycle after one in which `banks_idle` was high and `cke` was high in that cycle and in the one before it. With `cke` rising in cycle K and all else ready, the first load appears in cycle K+2.
- R4: Two loads are never closer than TMRD cycles. When the preconditions stay met, loads of one sequence are exactly TMRD cycles apart.
- R5: The main register image holds burst length in A[2:0], burst type in A3, CAS latency in A[6:4], 0 in A7, DLL reset in A8, write recovery in A[11:9], power-down mode in A12 and 0 in A13.
- R6: The burst-length field is 3'b011 when `bl8` is 1 (burst of 8) and 3'b010 otherwise (burst of 4). No other code is ever issued.
- R7: Extended register loads carry `emr1`, `emr2` or `emr3` unchanged as the full 14-bit address.
- R8: `ready` is low from reset until the fourth load of the sequence, and it is never high during a load. It rises exactly TMRD cycles after the final load cycle.
- R9: A `reprog_req` pulse while `ready` is high drops `ready` in the next cycle. It then reissues all four loads with complete images taken from the current configuration. No load is issued while `banks_idle` stays low.
- R10: During reset the pins carry a no-operation, `ba` and `addr` are zero, and `ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cke | input | 1 | Clock-enable level currently driven to the memory |
| banks_idle | input | 1 | High when every bank is precharged |
| reprog_req | input | 1 | Request to rerun the load sequence |
| order | input | 8 | Bank-address code for each of the four loads, load k in bits [2k+1:2k] |
| bl8 | input | 1 | 1: burst of 8, 0: burst of 4 |
| bt_intlv | input | 1 | Burst type, 1 interleaved |
| cas_lat | input | 3 | CAS latency code |
| dll_rst | input | 1 | DLL reset bit |
| wr_rec | input | 3 | Write recovery code |
| pd_slow | input | 1 | Power-down mode bit |
| emr1 | input | 14 | Extended register 1 image |
| emr2 | input | 14 | Extended register 2 image |
| emr3 | input | 14 | Extended register 3 image |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address |
| addr | output | 14 | Address bus |
| ready | output | 1 | Read and write traffic may start |

## Verification
An internal fault shows at the pins within one command slot. A wrong slot index gives a bank-address sequence out of the configured order on the next load. A wrong gap counter moves the spacing between loads away from TMRD. A lost clock-enable history brings the first load one cycle too early, and a faulty sequence state raises `ready` before the fourth load or at the wrong cycle after it. The bench logs every load with its cycle number, so each of these faults appears as a mismatch in bank code, image, spacing or ready timing.

// File: rtl/ddr2_mrs_pkg.sv
// Shared types and encodings for the mode register load sequencer.
// Assumes a 14-bit address bus and four loadable registers.
package ddr2_mrs_pkg;
    localparam int ADDR_W = 14;
    localparam int NREG   = 4;

    typedef logic [1:0] bsel_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } cmd_t;

    localparam cmd_t CMD_NOP  = '{cs_n: 1'b0, ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam cmd_t CMD_LOAD = '{cs_n: 1'b0, ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

    localparam bsel_t SEL_MR   = 2'd0;
    localparam bsel_t SEL_EMR1 = 2'd1;
    localparam bsel_t SEL_EMR2 = 2'd2;
    localparam bsel_t SEL_EMR3 = 2'd3;

    localparam logic [2:0] BL_CODE4 = 3'b010;
    localparam logic [2:0] BL_CODE8 = 3'b011;

    typedef struct packed {
        logic       bl8;
        logic       bt;
        logic [2:0] cl;
        logic       dll_rst;
        logic [2:0] wr;
        logic       pd;
    } mr_cfg_t;
endpackage

// File: rtl/ddr2_mr_encode.sv
// Builds the complete main mode register image from its fields.
// Assumes: test-mode bit and top address bit are always written as zero.
module ddr2_mr_encode
    import ddr2_mrs_pkg::*;
(
    input  mr_cfg_t             cfg,
    output logic [ADDR_W-1:0]   image
);
    // Place each field at its fixed bit position.
    always_comb begin
        image        = '0;
        image[2:0]   = cfg.bl8 ? BL_CODE8 : BL_CODE4;
        image[3]     = cfg.bt;
        image[6:4]   = cfg.cl;
        image[7]     = 1'b0;
        image[8]     = cfg.dll_rst;
        image[11:9]  = cfg.wr;
        image[12]    = cfg.pd;
        image[13]    = 1'b0;
    end
endmodule

// File: rtl/ddr2_mrs_gap.sv
// Counts the mode register cycle time after each load.
// Assumes TMRD >= 1; done is high when a new command may be issued.
module ddr2_mrs_gap #(
    parameter int TMRD = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic done
);
    localparam int CW = (TMRD < 2) ? 1 : $clog2(TMRD + 1);

    logic [CW-1:0] cnt;

    // Reload on each load command, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= CW'(TMRD - 1);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign done = (cnt == '0);

    AST_NO_EARLY_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> done); // R4
endmodule

// File: rtl/ddr2_mrs_ctrl.sv
// Sequence state: walks the load slots, waits out the final gap, holds ready.
// Assumes go_ok already combines bank-idle and clock-enable history.
module ddr2_mrs_ctrl #(
    parameter int NREG = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     go_ok,
    input  logic                     gap_done,
    input  logic                     reprog_req,
    output logic                     issue,
    output logic [$clog2(NREG)-1:0]  slot,
    output logic                     ready
);
    localparam int IW = $clog2(NREG);

    typedef enum logic [1:0] {S_RUN, S_TAIL, S_IDLE} st_t;
    st_t st;

    // A load is issued when running, preconditions hold and the gap expired.
    always_comb issue = (st == S_RUN) && go_ok && gap_done;

    // Advance slots, finish after the last gap, restart on request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st    <= S_RUN;
            slot  <= '0;
            ready <= 1'b0;
        end else begin
            case (st)
                S_RUN: if (issue) begin
                    if (slot == IW'(NREG - 1)) st <= S_TAIL;
                    else                       slot <= slot + 1'b1;
                end
                S_TAIL: if (gap_done) begin
                    st    <= S_IDLE;
                    ready <= 1'b1;
                    slot  <= '0;
                end
                S_IDLE: if (reprog_req) begin
                    st    <= S_RUN;
                    ready <= 1'b0;
                end
                default: st <= S_RUN;
            endcase
        end
    end

    AST_REPROG_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && reprog_req) |=> !ready); // R9
    AST_NO_ISSUE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !issue); // R8
endmodule

// File: rtl/ddr2_mrs_seq.sv
// Top: issues the four register loads after reset and on request.
// Assumes cke mirrors the pin driven to the memory and banks_idle is
// supplied by the bank state tracker. Command pins are registered.
module ddr2_mrs_seq
    import ddr2_mrs_pkg::*;
#(
    parameter int TMRD = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cke,
    input  logic        banks_idle,
    input  logic        reprog_req,
    input  logic [7:0]  order,
    input  logic        bl8,
    input  logic        bt_intlv,
    input  logic [2:0]  cas_lat,
    input  logic        dll_rst,
    input  logic [2:0]  wr_rec,
    input  logic        pd_slow,
    input  logic [13:0] emr1,
    input  logic [13:0] emr2,
    input  logic [13:0] emr3,
    output logic        cs_n,
    output logic        ras_n,
    output logic        cas_n,
    output logic        we_n,
    output logic [1:0]  ba,
    output logic [13:0] addr,
    output logic        ready
);
    localparam int IW = $clog2(NREG);

    logic              cke_q;
    logic              go_ok;
    logic              gap_done;
    logic              issue;
    logic [IW-1:0]     slot;
    bsel_t             sel;
    mr_cfg_t           mr_cfg;
    logic [ADDR_W-1:0] mr_img;
    logic [ADDR_W-1:0] img_sel;
    cmd_t              cmd_q;

    // Remember last cycle's clock-enable level.
    always_ff @(posedge clk) begin
        if (!rst_n) cke_q <= 1'b0;
        else        cke_q <= cke;
    end

    // Preconditions for a load: all banks idle, cke high now and before.
    always_comb go_ok = banks_idle && cke && cke_q;

    // Gather main register fields.
    always_comb mr_cfg = '{bl8: bl8, bt: bt_intlv, cl: cas_lat,
                           dll_rst: dll_rst, wr: wr_rec, pd: pd_slow};

    ddr2_mr_encode u_enc (.cfg(mr_cfg), .image(mr_img));

    ddr2_mrs_gap #(.TMRD(TMRD)) u_gap (
        .clk(clk), .rst_n(rst_n), .load(issue), .done(gap_done)
    );

    ddr2_mrs_ctrl #(.NREG(NREG)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .go_ok(go_ok), .gap_done(gap_done),
        .reprog_req(reprog_req), .issue(issue), .slot(slot), .ready(ready)
    );

    // Look up the register targeted by the current slot.
    always_comb sel = order[{slot, 1'b0} +: 2];

    // Pick the image for the selected register.
    always_comb begin
        case (sel)
            SEL_MR:   img_sel = mr_img;
            SEL_EMR1: img_sel = emr1;
            SEL_EMR2: img_sel = emr2;
            default:  img_sel = emr3;
        endcase
    end

    // Register the command, bank address and address onto the pins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q <= CMD_NOP;
            ba    <= '0;
            addr  <= '0;
        end else if (issue) begin
            cmd_q <= CMD_LOAD;
            ba    <= sel;
            addr  <= img_sel;
        end else begin
            cmd_q <= CMD_NOP;
            ba    <= '0;
            addr  <= '0;
        end
    end

    assign cs_n  = cmd_q.cs_n;
    assign ras_n = cmd_q.ras_n;
    assign cas_n = cmd_q.cas_n;
    assign we_n  = cmd_q.we_n;

    logic load_now;
    assign load_now = !cs_n && !ras_n && !cas_n && !we_n;

    AST_LOAD_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |-> $past(banks_idle)); // R3
    AST_LOAD_NEEDS_CKE: assert property (@(posedge clk) disable iff (!rst_n)
        load_now |-> ($past(cke) && $past(cke, 2))); // R3
    AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> !load_now); // R8
    AST_MR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (load_now && ba == SEL_MR) |->
        ((addr[2:0] == BL_CODE4 || addr[2:0] == BL_CODE8) && !addr[7] && !addr[13])); // R6

    generate
        if (TMRD > 1) begin : g_spacing
            AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (!rst_n)
                load_now |=> !load_now); // R4
        end
    endgenerate
endmodule

// File: tb/ddr2_mrs_seq_test.sv
module ddr2_mrs_seq_test;
    localparam int TMRD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cke = 1'b0;
    logic        banks_idle = 1'b1;
    logic        reprog_req = 1'b0;
    logic [7:0]  order = 8'h1E;
    logic        bl8 = 1'b1;
    logic        bt_intlv = 1'b0;
    logic [2:0]  cas_lat = 3'd4;
    logic        dll_rst = 1'b1;
    logic [2:0]  wr_rec = 3'd3;
    logic        pd_slow = 1'b0;
    logic [13:0] emr1 = 14'h0246;
    logic [13:0] emr2 = 14'h0080;
    logic [13:0] emr3 = 14'h0015;
    logic        cs_n, ras_n, cas_n, we_n, ready;
    logic [1:0]  ba;
    logic [13:0] addr;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    logic [1:0]  lg_ba [64];
    logic [13:0] lg_addr [64];
    int          lg_cyc [64];
    int          lg_n = 0;
    int          bad_cmd = 0;
    int          rdy_bad = 0;
    int          rdy_rise = -1;
    logic        rdy_prev = 1'b0;

    ddr2_mrs_seq #(.TMRD(TMRD)) uut (
        .clk(clk), .rst_n(rst_n), .cke(cke), .banks_idle(banks_idle),
        .reprog_req(reprog_req), .order(order), .bl8(bl8), .bt_intlv(bt_intlv),
        .cas_lat(cas_lat), .dll_rst(dll_rst), .wr_rec(wr_rec), .pd_slow(pd_slow),
        .emr1(emr1), .emr2(emr2), .emr3(emr3), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr), .ready(ready)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Log every load and flag malformed commands away from the edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (!cs_n && !ras_n && !cas_n && !we_n) begin
                if (lg_n < 64) begin
                    lg_ba[lg_n]   = ba;
                    lg_addr[lg_n] = addr;
                    lg_cyc[lg_n]  = cyc;
                end
                lg_n = lg_n + 1;
                if (ready) rdy_bad = rdy_bad + 1;
            end else if (!(cs_n == 1'b0 && ras_n && cas_n && we_n)) begin
                bad_cmd = bad_cmd + 1;
            end
            if (ready && !rdy_prev) rdy_rise = cyc;
            rdy_prev = ready;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    function automatic logic [13:0] exp_img(input logic [1:0] code);
        case (code)
            2'd0: exp_img = {1'b0, pd_slow, wr_rec, dll_rst, 1'b0, cas_lat,
                             bt_intlv, (bl8 ? 3'b011 : 3'b010)};
            2'd1: exp_img = emr1;
            2'd2: exp_img = emr2;
            default: exp_img = emr3;
        endcase
    endfunction

    task automatic wait_ready();
        for (int i = 0; i < 200; i++) begin
            if (ready) break;
            step();
        end
    endtask

    // Check four logged loads from base: order, images, spacing, ready timing.
    task automatic verify_seq(input int base, input string tag);
        chk({tag, " R8 load count"}, lg_n - base, 4);
        for (int k = 0; k < 4; k++) begin
            chk({tag, " R2 bank code"}, int'(lg_ba[base+k]), int'(order[2*k +: 2]));
            chk({tag, " R5 R7 image"}, int'(lg_addr[base+k]), int'(exp_img(lg_ba[base+k])));
            if (k > 0)
                chk({tag, " R4 spacing"}, lg_cyc[base+k] - lg_cyc[base+k-1], TMRD);
        end
        chk({tag, " R8 ready rise"}, rdy_rise, lg_cyc[base+3] + TMRD);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        cke = 1'b0;
        repeat (4) step();
        chk("R10 cs_n in reset", int'(cs_n), 0);
        chk("R10 ras_n in reset", int'(ras_n), 1);
        chk("R10 addr in reset", int'(addr), 0);
        chk("R10 ready in reset", int'(ready), 0);
        rst_n = 1'b1;
        repeat (6) step();
        chk("R3 no load with cke low", lg_n, 0);
        chk("R8 ready low before loads", int'(ready), 0);
    endtask

    task automatic t_init();
        int k0;
        int base;
        base = lg_n;
        cke = 1'b1;
        k0 = cyc;
        wait_ready();
        step();
        chk("R3 first load two cycles after cke", lg_cyc[base], k0 + 2);
        verify_seq(base, "init");
        chk("R6 burst 8 code", int'(lg_addr[base+3][2:0]), 3);
    endtask

    task automatic t_reprog_held();
        int k0;
        int base;
        banks_idle = 1'b0;
        order = 8'hB4;
        bl8 = 1'b0;
        bt_intlv = 1'b1;
        cas_lat = 3'd5;
        dll_rst = 1'b0;
        wr_rec = 3'd6;
        pd_slow = 1'b1;
        emr1 = 14'h1401;
        emr2 = 14'h0000;
        emr3 = 14'h2003;
        base = lg_n;
        step();
        chk("R9 ready high before request", int'(ready), 1);
        reprog_req = 1'b1;
        step();
        reprog_req = 1'b0;
        chk("R9 ready drops next cycle", int'(ready), 0);
        repeat (10) step();
        chk("R9 no load while banks busy", lg_n - base, 0);
        chk("R9 ready stays low while held", int'(ready), 0);
        banks_idle = 1'b1;
        k0 = cyc;
        wait_ready();
        step();
        chk("R9 load follows banks idle", lg_cyc[base], k0 + 1);
        verify_seq(base, "reprog");
        chk("R6 burst 4 code", int'(lg_addr[base][2:0]), 2);
    endtask

    task automatic t_reprog_direct();
        int base;
        order = 8'h1B;
        bl8 = 1'b1;
        cas_lat = 3'd3;
        base = lg_n;
        step();
        reprog_req = 1'b1;
        step();
        reprog_req = 1'b0;
        wait_ready();
        step();
        verify_seq(base, "direct");
        repeat (8) step();
        chk("R8 no load after ready", lg_n - base, 4);
        chk("R1 command pin shapes", bad_cmd, 0);
        chk("R8 ready never during load", rdy_bad, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails = fails + 1;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_init();
        t_reprog_held();
        t_reprog_direct();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule